// File: doc/BRIEF.md
# I2C Register Target with Update Hold

This block is an I2C-compatible target that lets a bus host read and write a bank of 8-bit registers through an internal register pointer. It filters SCL and SDA into the system clock domain, finds START, repeated START and STOP conditions, answers only its own fixed 7-bit address, and acknowledges the address, pointer and data bytes it accepts. A write sets the pointer with its first data byte and stores every following byte at the pointer, stepping the pointer after each one. A read uses the pointer left by an earlier write phase, usually joined by a repeated START. Each byte the host acknowledges moves the pointer on, and a NACK ends the read.

The register bank sits outside the block behind a plain write strobe and a combinational read port. The bank also holds an event queue and event counters, which are filled by other logic. A hold output tells that logic to defer its updates while the host's pointer sits in that window, so a transfer never sees a value caught half-way through an update.

The sequencer walks the states IDLE (bus free), ADDR (shifting the address byte), ADDR_ACK (driving the address acknowledge), PTR (shifting the pointer byte), PTR_ACK, WDATA (shifting a write byte), WDATA_ACK, RDATA (driving a read byte), RDATA_ACK (sampling the host's acknowledge) and IGNORE (released, waiting for the bus). START from any state goes to ADDR and STOP goes to IDLE. At each falling SCL edge: ADDR goes to ADDR_ACK on a match and to IGNORE otherwise. ADDR_ACK goes to PTR for a write and to RDATA for a read. PTR goes to PTR_ACK, then PTR_ACK goes to WDATA. WDATA and WDATA_ACK alternate. RDATA goes to RDATA_ACK. RDATA_ACK goes back to RDATA after an ACK and to IGNORE after a NACK.

Top module: `i2c_reg_target`

## Requirements
- R1: During and right after reset, SDA is released (`sda_pull_o` = 0), `hold_o` is 0 and no register write strobe is issued.
- R2: The target acknowledges, by pulling SDA low on the ninth clock, only an address byte whose upper seven bits equal 0x34 (bit 0 is R/W: 0 write, 1 read). On any other address it never pulls SDA and issues no writes until the next START or STOP.
- R3: In a write, the byte after the address is loaded into the pointer and acknowledged. Each following byte is acknowledged and written to the register the pointer selects.
- R4: After each written byte the pointer advances by one, wrapping from 0xFF to 0x00, so consecutive bytes go to consecutive registers.
- R5: After a repeated START with R/W = 1, the target shifts out the register at the current pointer, MSB first, with the pointer kept from the earlier write phase.
- R6: Each read byte that the host acknowledges (SDA low on the ninth clock) advances the pointer, and the next byte comes from the next register, wrapping from 0xFF to 0x00.
- R7: After a NACK on a read byte, the target releases SDA and drives no further data until the next START or STOP.
- R8: `hold_o` is 1 while a transfer is active and the pointer is in 0x20..0x27. It goes to 0 on STOP or START and stays 0 when the pointer is outside that range.
- R9: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it (open drain) |
| hold_o | output | 1 | Defer event queue and counter updates |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register index for the write |
| wr_data_o | output | 8 | Data for the write |
| rd_addr_o | output | 8 | Register index for reads (current pointer) |
| rd_data_i | input | 8 | Register contents at `rd_addr_o`, combinational |

## Verification
The hardest state to reach from the ports is a read whose pointer lies in the hold window, seen both across the repeated START and after the NACK. Here `hold_o` has to drop at the repeated START, come back once read data begins, and stay up in IGNORE until the STOP. The bench reaches it with a pointer-set write to 0x22, followed by a repeated START and a NACKed read, and checks `hold_o` at each of these points. A second hard case is pointer wrap during burst reads and writes. The stimulus starts those bursts at 0xFE so that both wrap at the third byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] scl_ff;
    logic [LAST:0] sda_ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[LAST-1:0], scl_i};
            sda_ff <= {sda_ff[LAST-1:0], sda_i};
        end
    end

    logic scl_prev, sda_prev;
    assign scl_s    = scl_ff[LAST-1];
    assign sda_s    = sda_ff[LAST-1];
    assign scl_prev = scl_ff[LAST];
    assign sda_prev = sda_ff[LAST];

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h34,
    parameter int         DATA_W   = 8,
    parameter int         PTR_W    = 8,
    parameter logic [7:0] HOLD_LO  = 8'h20,
    parameter logic [7:0] HOLD_HI  = 8'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic              hold_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  rd_addr_o
);
    localparam int               CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    tgt_state_e        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              rw_q, host_ack_q, hold_q;
    logic              addr_hit, in_window, rx_state, active_state;

    assign addr_hit     = (shreg_q[DATA_W-1 -: 7] == DEV_ADDR);
    assign in_window    = (ptr_q >= HOLD_LO) && (ptr_q <= HOLD_HI);
    assign rx_state     = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);
    assign active_state = (state_q == ST_PTR_ACK) || (state_q == ST_WDATA) ||
                          (state_q == ST_WDATA_ACK) || (state_q == ST_RDATA) ||
                          (state_q == ST_RDATA_ACK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: bus conditions first, then falling SCL edges
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (cnt_q == CNT_FULL) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (cnt_q == CNT_FULL) state_d = ST_PTR_ACK;
                ST_PTR_ACK:   state_d = ST_WDATA;
                ST_WDATA:     if (cnt_q == CNT_FULL) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: state_d = ST_WDATA;
                ST_RDATA:     if (cnt_q == CNT_LAST) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: state_d = host_ack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Shifter, bit counter, pointer, write strobe and hold flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            ptr_q      <= '0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            hold_q     <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_det || stop_det) begin
                cnt_q  <= '0;
                hold_q <= 1'b0;
            end else begin
                if (scl_rise && rx_state) begin
                    shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
                    cnt_q   <= cnt_q + CNT_ONE;
                end
                if (scl_rise && state_q == ST_RDATA_ACK) begin
                    host_ack_q <= ~sda_s;
                    if (!sda_s) ptr_q <= ptr_q + PTR_ONE;
                end
                if (scl_fall) begin
                    case (state_q)
                        ST_ADDR: if (cnt_q == CNT_FULL) begin
                            rw_q  <= shreg_q[0];
                            cnt_q <= '0;
                        end
                        ST_ADDR_ACK: begin
                            cnt_q <= '0;
                            if (rw_q) shreg_q <= rd_data_i;
                        end
                        ST_PTR: if (cnt_q == CNT_FULL) begin
                            ptr_q <= shreg_q;
                            cnt_q <= '0;
                        end
                        ST_WDATA: if (cnt_q == CNT_FULL) begin
                            wr_en_o   <= 1'b1;
                            wr_addr_o <= ptr_q;
                            wr_data_o <= shreg_q;
                            ptr_q     <= ptr_q + PTR_ONE;
                            cnt_q     <= '0;
                        end
                        ST_RDATA: begin
                            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                            cnt_q   <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_ONE;
                        end
                        ST_RDATA_ACK: if (host_ack_q) begin
                            shreg_q <= rd_data_i;
                            cnt_q   <= '0;
                        end
                        default: ;
                    endcase
                end
                if (active_state) hold_q <= in_window;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                              sda_pull_o = ~shreg_q[DATA_W-1];
            default:                               sda_pull_o = 1'b0;
        endcase
    end
    assign hold_o    = hold_q;
    assign rd_addr_o = ptr_q;

    // Checks
    assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);
    assert_ack_only_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |-> $past(addr_hit));
    assert_write_in_data_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (state_q == ST_WDATA_ACK));
    assert_ptr_step_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA_ACK && $past(state_q) == ST_WDATA) |-> (ptr_q == $past(ptr_q) + PTR_ONE));
    assert_hold_drops_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hold_o);
    assert_released_after_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RDATA_ACK && state_q == ST_IGNORE) |-> !sda_pull_o);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h34,
    parameter int         DATA_W      = 8,
    parameter int         PTR_W       = 8,
    parameter logic [7:0] HOLD_LO     = 8'h20,
    parameter logic [7:0] HOLD_HI     = 8'h27,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              hold_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .DATA_W   (DATA_W),
        .PTR_W    (PTR_W),
        .HOLD_LO  (HOLD_LO),
        .HOLD_HI  (HOLD_HI)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .rd_data_i  (rd_data_i),
        .sda_pull_o (sda_pull_o),
        .hold_o     (hold_o),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .rd_addr_o  (rd_addr_o)
    );
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
    localparam int Q = 10;
    localparam logic [7:0] AW = 8'h68;
    localparam logic [7:0] AR = 8'h69;
    localparam logic [15:0] VEC [6] = '{16'h03A5, 16'h105A, 16'h7F00, 16'h80FF, 16'h1FC3, 16'h283C};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, scl, sda_drv;
    logic sda_pull, hold, wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    wire sda_line = sda_drv & ~sda_pull;

    i2c_reg_target i_i2c_reg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .hold_o(hold), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    logic [7:0] bank [256];
    int n_run = 0, n_fail = 0, wr_count = 0, r9_viol = 0;
    logic pull_prev = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) if (wr_en) begin bank[wr_addr] <= wr_data; wr_count++; end
    assign rd_data = bank[rd_addr];

    always @(posedge clk) begin
        if (rst_n && scl && (sda_pull !== pull_prev)) r9_viol++;
        pull_prev <= sda_pull;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(); repeat (Q) @(negedge clk); endtask
    task automatic clk_bit(input logic b, output logic s);
        sda_drv = b; wait_q(); scl = 1'b1; wait_q(); s = sda_line; wait_q(); scl = 1'b0; wait_q();
    endtask
    task automatic bus_start();
        sda_drv = 1'b1; wait_q(); scl = 1'b1; wait_q(); sda_drv = 1'b0; wait_q(); scl = 1'b0; wait_q();
    endtask
    task automatic bus_stop();
        sda_drv = 1'b0; wait_q(); scl = 1'b1; wait_q(); sda_drv = 1'b1; wait_q(); wait_q();
    endtask
    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask
    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
        clk_bit(~give_ack, s);
    endtask
    task automatic write_burst(input logic [7:0] ptr, input logic [7:0] d [3], input int n, output logic ok);
        logic a;
        ok = 1'b1;
        bus_start();
        send_byte(AW, a); ok &= a;
        send_byte(ptr, a); ok &= a;
        for (int i = 0; i < n; i++) begin send_byte(d[i], a); ok &= a; end
        bus_stop();
    endtask
    task automatic read_burst(input logic [7:0] ptr, input int n, output logic [7:0] r [3], output logic ok);
        logic a;
        ok = 1'b1;
        bus_start();
        send_byte(AW, a); ok &= a;
        send_byte(ptr, a); ok &= a;
        bus_start();
        send_byte(AR, a); ok &= a;
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, r[i]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic ok, a;
        logic [7:0] d [3];
        logic [7:0] r [3];
        logic [7:0] x;
        int wc;
        rst_n = 1'b0; scl = 1'b1; sda_drv = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(sda_pull == 1'b0, "R1 sda released in reset", sda_pull, 0);
        check(hold == 1'b0, "R1 hold low in reset", hold, 0);
        check(wr_en == 1'b0, "R1 no write in reset", wr_en, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_pull == 1'b0 && hold == 1'b0 && wr_count == 0, "R1 idle after reset", sda_pull, 0);

        // R3/R5: table of single writes read back
        foreach (VEC[k]) begin
            d[0] = VEC[k][7:0];
            write_burst(VEC[k][15:8], d, 1, ok);
            check(ok, "R3 acks on single write", ok, 1);
            read_burst(VEC[k][15:8], 1, r, ok);
            check(ok, "R2 acks on read setup", ok, 1);
            check(r[0] == VEC[k][7:0], "R5 read back value", r[0], VEC[k][7:0]);
        end

        // R2: wrong address ignored
        d[0] = 8'h99;
        write_burst(8'h40, d, 1, ok);
        wc = wr_count;
        bus_start();
        send_byte(8'h6A, a);
        check(!a, "R2 no ack for address 0x35", a, 0);
        send_byte(8'h40, a);
        check(!a, "R2 no ack after mismatch", a, 0);
        send_byte(8'h11, a);
        bus_stop();
        check(wr_count == wc, "R2 no write after mismatch", wr_count, wc);
        read_burst(8'h40, 1, r, ok);
        check(r[0] == 8'h99, "R2 register untouched", r[0], 8'h99);

        // R4/R6: bursts with wrap at 0xFF
        d = '{8'h11, 8'h22, 8'h33};
        write_burst(8'hFE, d, 3, ok);
        check(ok, "R4 burst acks", ok, 1);
        read_burst(8'hFE, 3, r, ok);
        check(r[0] == 8'h11, "R6 burst byte 0", r[0], 8'h11);
        check(r[1] == 8'h22, "R4 burst byte 1 at 0xFF", r[1], 8'h22);
        check(r[2] == 8'h33, "R6 burst byte 2 wraps to 0x00", r[2], 8'h33);

        // R7: release after NACK
        bus_start();
        send_byte(AW, a); send_byte(8'h03, a);
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b0, x);
        check(x == 8'hA5, "R7 byte before NACK", x, 8'hA5);
        recv_byte(1'b0, x);
        check(x == 8'hFF, "R7 SDA released after NACK", x, 8'hFF);
        bus_stop();

        // R8: hold window
        bus_start();
        send_byte(AW, a); send_byte(8'h21, a);
        check(hold == 1'b1, "R8 hold after pointer 0x21", hold, 1);
        send_byte(8'h77, a);
        bus_stop();
        check(hold == 1'b0, "R8 hold clear after STOP", hold, 0);
        bus_start();
        send_byte(AW, a); send_byte(8'h22, a);
        check(hold == 1'b1, "R8 hold for read pointer 0x22", hold, 1);
        bus_start();
        check(hold == 1'b0, "R8 hold clear at repeated START", hold, 0);
        send_byte(AR, a);
        recv_byte(1'b0, x);
        check(hold == 1'b1, "R8 hold during read until STOP", hold, 1);
        bus_stop();
        check(hold == 1'b0, "R8 hold clear after read STOP", hold, 0);
        bus_start();
        send_byte(AW, a); send_byte(8'h30, a);
        check(hold == 1'b0, "R8 no hold outside window", hold, 0);
        bus_stop();

        // R9: drive changes only with SCL low
        check(r9_viol == 0, "R9 SDA changes with SCL high", r9_viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule